// File: doc/BRIEF.md
# Keyed Super I/O Configuration Register File

This block is the configuration front end of a legacy-PC peripheral controller. It sits on an 8-bit I/O bus and answers three consecutive port addresses: a key port, an index port and a data port. Software first writes an unlock byte to the key port. It then selects one of 22 internal configuration registers through the index port and reads or writes that register through the data port.

The unlock byte is not fixed. It is 0x88 with its low bit taken from bit 5 of register 0x0C, so reprogramming that register changes the byte needed the next time the unlock sequence is run. A protection flag, set by a write to register 9, freezes the whole register file against further writes. It also hides every register from reads except the drive-type register 7.

The stored register bits are decoded into ready-to-use settings: a base I/O address, an interrupt number and an enable for each of two serial ports and one parallel port, plus a base address and an enable for a floppy controller. All bus inputs and outputs are plain strobed pins with no handshake. A read returns data in the same cycle as the read strobe.

Top module: `keyed_sio_cfg`

## Requirements
- R1: After reset the block is locked and the protection flag is clear. Registers 0x00, 0x01, 0x03, 0x07, 0x0A, 0x0C and 0x0D hold 0x50, 0x2C, 0x30, 0xF5, 0x1F, 0x2C and 0xA3. Register 0x09 holds the value on `strap_cfg9`. Every other register holds 0x00.
- R2: A write to the key port (BASE+0) unlocks the block when the byte equals {7'b1000100, bit 5 of register 0x0C}. Any other byte locks it. The reset key is 0x89.
- R3: A write to the index port (BASE+1) loads the index only if the byte is 0x15 or lower. A larger byte leaves the index unchanged. While unlocked, a read of the index port returns the index.
- R4: While locked, every read returns 0xFF and data-port writes change no register. Index-port writes are still accepted.
- R5: While unlocked with the protection flag clear, a data-port (BASE+2) write stores the byte in the indexed register, and a data-port read returns it. A write to register 6 is stored ANDed with 0xF3.
- R6: An accepted write to register 9 loads the protection flag from bit 6 of the byte. While the flag is set, data-port writes are ignored, so the flag stays set until reset. Data reads return 0xFF, except register 7, which still returns its stored value.
- R7: Serial port u (u = 0 or 1) takes its select code from {reg1[2+u], reg1[u]} and its override from reg3[3-u].
  - With the override set, port 0 is at 0x2F8 and port 1 is at 0x3F8.
  - Otherwise code 0 gives 0x2E8 (port 0) or 0x3E8 (port 1), code 1 gives 0x3E8 or 0x2E8, code 2 gives 0x3F8 or 0x2F8, and code 3 disables the port.
  - The IRQ is 4 for any base in the 0x3xx range and 3 for any base in the 0x2xx range.
- R8: Serial port 0 is disabled by reg4[5] and serial port 1 by reg4[4]. A disabled port reports base 0 and IRQ 0.
- R9: The parallel port code {reg1[5], reg1[4]} selects 0x3BC/IRQ7 (code 0), 0x278/IRQ5 (code 1), 0x378/IRQ7 (code 2) or disabled (code 3). Reg4[7] also disables the port. A disabled port reports base 0 and IRQ 0.
- R10: The floppy controller is enabled when reg0[5] is 0. Its base is 0x3F0 when reg0[4] is 1 and 0x370 when reg0[4] is 0.
- R11: A port access is decoded only on an exact address match with the matching strobe. A decoded setting changes immediately after the clock edge that captures the data write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_cfg9 | input | 8 | Reset value of register 9 |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0xFF when nothing is returned) |
| ser0_en | output | 1 | Serial port 0 enable |
| ser0_base | output | 16 | Serial port 0 base address |
| ser0_irq | output | 4 | Serial port 0 IRQ number |
| ser1_en | output | 1 | Serial port 1 enable |
| ser1_base | output | 16 | Serial port 1 base address |
| ser1_irq | output | 4 | Serial port 1 IRQ number |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base address |
| par_irq | output | 4 | Parallel port IRQ number |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base address |

## Verification
The bench builds the block with its default parameters: port base 0x250, 16-bit addresses and 22 registers. At that size every register can be written and read back. It also makes an exhaustive sweep practical: all 256 values of register 1, all four serial override combinations and all sixteen settings of the disable nibble of register 4. That sweep covers every serial and parallel select code together with every override and disable. The bench also drives both floppy bits through all four combinations and runs both key values that the key bit allows.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef struct packed {
    logic        en;
    logic [15:0] base;
    logic [3:0]  irq;
  } res_cfg_t;

  localparam int REG_FLOPPY_MODE = 6;
  localparam int REG_DRIVE_TYPE  = 7;
  localparam int REG_LOCKCTL     = 9;
  localparam logic [7:0] FLOPPY_MODE_MASK = 8'hF3;

  function automatic logic [7:0] reg_default(input int idx, input logic [7:0] strap);
    case (idx)
      0:       return 8'h50;
      1:       return 8'h2C;
      3:       return 8'h30;
      7:       return 8'hF5;
      9:       return strap;
      10:      return 8'h1F;
      12:      return 8'h2C;
      13:      return 8'hA3;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_access.sv
module sio_cfg_access #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0250,
  parameter int          NREGS     = 22,
  localparam int         IDX_W     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  input  logic              key_lsb,
  output logic              unlocked_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              data_we,
  output logic              idx_re,
  output logic              data_re
);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(BASE_ADDR + 16'd1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + 16'd2);
  localparam logic [7:0]        MAX_IDX = 8'(NREGS - 1);

  logic hit_key, hit_idx, hit_data;
  assign hit_key  = (addr == A_KEY);
  assign hit_idx  = (addr == A_IDX);
  assign hit_data = (addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      if (wr && hit_key)
        unlocked_q <= (wdata == {7'b1000100, key_lsb});
      if (wr && hit_idx && (wdata <= MAX_IDX))
        idx_q <= wdata[IDX_W-1:0];
    end
  end

  assign data_we = wr && hit_data && unlocked_q;
  assign idx_re  = rd && hit_idx && unlocked_q;
  assign data_re = rd && hit_data && unlocked_q;
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int  NREGS = 22,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       strap,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_val,
  output logic             prot_q,
  output logic [1:0]       fdc_bits,
  output logic [5:0]       sel_bits,
  output logic [1:0]       ovr_bits,
  output logic [3:0]       dis_bits,
  output logic             key_bit
);
  logic [NREGS-1:0][7:0] regs;
  logic accept;
  assign accept = we && !prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= reg_default(i, strap);
      prot_q <= 1'b0;
    end else if (accept) begin
      if (idx == IDX_W'(REG_FLOPPY_MODE))
        regs[idx] <= wdata & FLOPPY_MODE_MASK;
      else
        regs[idx] <= wdata;
      if (idx == IDX_W'(REG_LOCKCTL))
        prot_q <= wdata[6];
    end
  end

  always_comb begin
    if (idx == IDX_W'(REG_DRIVE_TYPE)) rd_val = regs[REG_DRIVE_TYPE];
    else if (prot_q)                   rd_val = 8'hFF;
    else                               rd_val = regs[idx];
  end

  assign fdc_bits = regs[0][5:4];
  assign sel_bits = regs[1][5:0];
  assign ovr_bits = regs[3][3:2];
  assign dis_bits = regs[4][7:4];
  assign key_bit  = regs[12][5];
endmodule

// File: rtl/sio_cfg_serial_map.sv
module sio_cfg_serial_map
  import sio_cfg_pkg::*;
#(
  parameter int PORT_ID = 0
) (
  input  logic [1:0] code,
  input  logic       ovr,
  input  logic       dis,
  output res_cfg_t   cfg
);
  localparam logic [15:0] A_OVR = (PORT_ID == 0) ? 16'h02F8 : 16'h03F8;
  localparam logic [15:0] A_C0  = (PORT_ID == 0) ? 16'h02E8 : 16'h03E8;
  localparam logic [15:0] A_C1  = (PORT_ID == 0) ? 16'h03E8 : 16'h02E8;
  localparam logic [15:0] A_C2  = (PORT_ID == 0) ? 16'h03F8 : 16'h02F8;

  logic [15:0] base;
  logic        live;
  always_comb begin
    live = 1'b1;
    if (ovr) base = A_OVR;
    else begin
      case (code)
        2'd0:    base = A_C0;
        2'd1:    base = A_C1;
        2'd2:    base = A_C2;
        default: begin base = 16'h0; live = 1'b0; end
      endcase
    end
    if (dis) live = 1'b0;
    cfg.en   = live;
    cfg.base = live ? base : 16'h0;
    cfg.irq  = !live ? 4'd0 : (base[8] ? 4'd4 : 4'd3);
  end
endmodule

// File: rtl/sio_cfg_misc_map.sv
module sio_cfg_misc_map
  import sio_cfg_pkg::*;
(
  input  logic [1:0] par_code,
  input  logic       par_dis,
  input  logic [1:0] fdc_bits,
  output res_cfg_t   par_cfg,
  output logic       fdc_en,
  output logic [15:0] fdc_base
);
  always_comb begin
    par_cfg = '0;
    if (!par_dis) begin
      case (par_code)
        2'd0:    par_cfg = '{en: 1'b1, base: 16'h03BC, irq: 4'd7};
        2'd1:    par_cfg = '{en: 1'b1, base: 16'h0278, irq: 4'd5};
        2'd2:    par_cfg = '{en: 1'b1, base: 16'h0378, irq: 4'd7};
        default: par_cfg = '0;
      endcase
    end
  end
  assign fdc_en   = !fdc_bits[1];
  assign fdc_base = fdc_bits[0] ? 16'h03F0 : 16'h0370;
endmodule

// File: rtl/keyed_sio_cfg.sv
module keyed_sio_cfg
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0250,
  parameter int          NREGS     = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        strap_cfg9,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              ser0_en,
  output logic [15:0]       ser0_base,
  output logic [3:0]        ser0_irq,
  output logic              ser1_en,
  output logic [15:0]       ser1_base,
  output logic [3:0]        ser1_irq,
  output logic              par_en,
  output logic [15:0]       par_base,
  output logic [3:0]        par_irq,
  output logic              fdc_en,
  output logic [15:0]       fdc_base
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int NSER  = 2;

  logic             unlocked_q, prot_q, key_bit;
  logic [IDX_W-1:0] idx_q;
  logic             data_we, idx_re, data_re;
  logic [7:0]       rd_val;
  logic [1:0]       fdc_bits, ovr_bits;
  logic [5:0]       sel_bits;
  logic [3:0]       dis_bits;
  res_cfg_t         ser_cfg [NSER];
  res_cfg_t         par_cfg;

  sio_cfg_access #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NREGS(NREGS)) acc_i (
    .clk(clk), .rst_n(rst_n), .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .wdata(io_wdata), .key_lsb(key_bit), .unlocked_q(unlocked_q), .idx_q(idx_q),
    .data_we(data_we), .idx_re(idx_re), .data_re(data_re)
  );

  sio_cfg_regfile #(.NREGS(NREGS)) rf_i (
    .clk(clk), .rst_n(rst_n), .strap(strap_cfg9), .we(data_we), .idx(idx_q),
    .wdata(io_wdata), .rd_val(rd_val), .prot_q(prot_q), .fdc_bits(fdc_bits),
    .sel_bits(sel_bits), .ovr_bits(ovr_bits), .dis_bits(dis_bits), .key_bit(key_bit)
  );

  for (genvar u = 0; u < NSER; u++) begin : g_ser
    sio_cfg_serial_map #(.PORT_ID(u)) map_i (
      .code({sel_bits[2+u], sel_bits[u]}),
      .ovr (ovr_bits[1-u]),
      .dis (dis_bits[1-u]),
      .cfg (ser_cfg[u])
    );
  end

  sio_cfg_misc_map misc_i (
    .par_code(sel_bits[5:4]), .par_dis(dis_bits[3]), .fdc_bits(fdc_bits),
    .par_cfg(par_cfg), .fdc_en(fdc_en), .fdc_base(fdc_base)
  );

  always_comb begin
    if (idx_re)       io_rdata = 8'(idx_q);
    else if (data_re) io_rdata = rd_val;
    else              io_rdata = 8'hFF;
  end

  assign ser0_en   = ser_cfg[0].en;
  assign ser0_base = ser_cfg[0].base;
  assign ser0_irq  = ser_cfg[0].irq;
  assign ser1_en   = ser_cfg[1].en;
  assign ser1_base = ser_cfg[1].base;
  assign ser1_irq  = ser_cfg[1].irq;
  assign par_en    = par_cfg.en;
  assign par_base  = par_cfg.base;
  assign par_irq   = par_cfg.irq;
endmodule

// File: rtl/keyed_sio_cfg_chk.sv
module keyed_sio_cfg_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0250,
  parameter int          IDX_W     = 5,
  parameter int          NREGS     = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              unlocked,
  input logic              prot,
  input logic [IDX_W-1:0]  idx,
  input logic              ser0_en,
  input logic [15:0]       ser0_base,
  input logic [3:0]        ser0_irq,
  input logic              par_en,
  input logic [15:0]       par_base,
  input logic              fdc_en,
  input logic [15:0]       fdc_base
);
  a_r2_wrong_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(BASE_ADDR) && io_wdata[7:1] != 7'h44) |=> !unlocked);

  a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx) <= NREGS - 1);

  a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !unlocked) |-> io_rdata == 8'hFF);

  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(BASE_ADDR + 16'd2) && !unlocked)
      |=> ($stable(ser0_base) && $stable(par_base) && $stable(fdc_en) && $stable(par_en)));

  a_r6_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> prot);

  a_r7_ser0_irq_matches_base: assert property (@(posedge clk) disable iff (!rst_n)
    ser0_en |-> (ser0_irq == (ser0_base[8] ? 4'd4 : 4'd3)));

  a_r10_fdc_base_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_en |-> (fdc_base == 16'h03F0 || fdc_base == 16'h0370));
endmodule

bind keyed_sio_cfg keyed_sio_cfg_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W($clog2(NREGS)), .NREGS(NREGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked_q), .prot(prot_q),
  .idx(idx_q), .ser0_en(ser0_en), .ser0_base(ser0_base), .ser0_irq(ser0_irq),
  .par_en(par_en), .par_base(par_base), .fdc_en(fdc_en), .fdc_base(fdc_base)
);

// File: tb/keyed_sio_cfg_tb_top.sv
module keyed_sio_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0250;
  localparam logic [7:0]  STRAP = 8'h1C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic ser0_en, ser1_en, par_en, fdc_en;
  logic [15:0] ser0_base, ser1_base, par_base, fdc_base;
  logic [3:0] ser0_irq, ser1_irq, par_irq;

  int checks = 0, errors = 0;
  logic [7:0] sh [22];

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_sio_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .strap_cfg9(STRAP), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ser0_en(ser0_en), .ser0_base(ser0_base), .ser0_irq(ser0_irq),
    .ser1_en(ser1_en), .ser1_base(ser1_base), .ser1_irq(ser1_irq),
    .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
    .fdc_en(fdc_en), .fdc_base(fdc_base)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata; io_rd = 1'b0;
  endtask

  task automatic wreg(input int i, input logic [7:0] v);
    bus_wr(BASE + 16'd1, 8'(i));
    bus_wr(BASE + 16'd2, v);
    sh[i] = (i == 6) ? (v & 8'hF3) : v;
  endtask

  task automatic rreg(input int i, output logic [7:0] v);
    bus_wr(BASE + 16'd1, 8'(i));
    bus_rd(BASE + 16'd2, v);
  endtask

  function automatic logic [20:0] ser_exp(input int u, input logic [7:0] r1, r3, r4);
    logic [1:0] code;
    logic [15:0] b;
    logic en;
    code = {r1[2+u], r1[u]};
    en = 1'b1;
    if (r3[3-u]) b = (u == 0) ? 16'h2F8 : 16'h3F8;
    else if (code == 2'd0) b = (u == 0) ? 16'h2E8 : 16'h3E8;
    else if (code == 2'd1) b = (u == 0) ? 16'h3E8 : 16'h2E8;
    else if (code == 2'd2) b = (u == 0) ? 16'h3F8 : 16'h2F8;
    else begin b = 16'h0; en = 1'b0; end
    if (r4[5-u]) en = 1'b0;
    if (!en) return 21'h0;
    return {1'b1, b, (b >= 16'h300) ? 4'd4 : 4'd3};
  endfunction

  function automatic logic [20:0] par_exp(input logic [7:0] r1, r4);
    if (r4[7]) return 21'h0;
    case (r1[5:4])
      2'd0: return {1'b1, 16'h3BC, 4'd7};
      2'd1: return {1'b1, 16'h278, 4'd5};
      2'd2: return {1'b1, 16'h378, 4'd7};
      default: return 21'h0;
    endcase
  endfunction

  function automatic logic [7:0] rst_exp(input int i);
    case (i)
      0: return 8'h50;  1: return 8'h2C;  3: return 8'h30;  7: return 8'hF5;
      9: return STRAP;  10: return 8'h1F; 12: return 8'h2C; 13: return 8'hA3;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1/R4: locked after reset
    bus_rd(BASE + 16'd2, v); check("R1 locked data read", v, 8'hFF);
    bus_rd(BASE + 16'd1, v); check("R4 locked index read", v, 8'hFF);
    check("R1 ser0 reset", {ser0_en, ser0_base, ser0_irq}, {1'b1, 16'h3F8, 4'd4});
    check("R1 ser1 reset", {ser1_en, ser1_base, ser1_irq}, {1'b1, 16'h2F8, 4'd3});
    check("R1 par reset", {par_en, par_base, par_irq}, {1'b1, 16'h378, 4'd7});
    check("R1 fdc reset", {fdc_en, fdc_base}, {1'b1, 16'h3F0});

    // R2: reset key
    bus_wr(BASE, 8'h89);
    for (int i = 0; i < 22; i++) begin
      rreg(i, v); check("R1 reset register value", v, rst_exp(i));
      sh[i] = rst_exp(i);
    end

    // R2: key follows register 0x0C bit 5
    bus_wr(BASE, 8'h88);
    bus_rd(BASE + 16'd1, v); check("R2 wrong key locks", v, 8'hFF);
    bus_wr(BASE, 8'h89);
    wreg(12, 8'h0C);
    bus_wr(BASE, 8'h89);
    bus_rd(BASE + 16'd1, v); check("R2 old key rejected", v, 8'hFF);
    bus_wr(BASE, 8'h88);
    bus_rd(BASE + 16'd1, v); check("R2 new key 0x88 accepted", v, 8'd12);
    wreg(12, 8'h2C);
    bus_wr(BASE, 8'h89);
    bus_rd(BASE + 16'd1, v); check("R2 key back to 0x89", v, 8'd12);

    // R3: index range
    bus_wr(BASE + 16'd1, 8'h05);
    bus_wr(BASE + 16'd1, 8'h16);
    bus_rd(BASE + 16'd1, v); check("R3 index 0x16 rejected", v, 8'h05);
    bus_wr(BASE + 16'd1, 8'hFF);
    bus_rd(BASE + 16'd1, v); check("R3 index 0xFF rejected", v, 8'h05);
    bus_wr(BASE + 16'd1, 8'h15);
    bus_rd(BASE + 16'd1, v); check("R3 index 0x15 accepted", v, 8'h15);

    // R5: write/read every register, register 6 masked
    for (int i = 0; i < 22; i++) begin
      logic [7:0] w;
      w = 8'(i * 37 + 5);
      if (i == 9) w = w & 8'hBF;
      if (i == 12) w = 8'h2C;
      wreg(i, w);
    end
    for (int i = 0; i < 22; i++) begin
      rreg(i, v); check("R5 readback", v, sh[i]);
    end
    wreg(6, 8'hFF);
    rreg(6, v); check("R5 register 6 mask", v, 8'hF3);

    // R10: floppy bits
    for (int k = 0; k < 4; k++) begin
      wreg(0, {2'b0, 2'(k), 4'b0});
      check("R10 fdc", {fdc_en, fdc_base}, {~k[1], k[0] ? 16'h3F0 : 16'h370});
    end
    wreg(0, 8'h50);

    // R11: timing of output update, exact address and strobe
    bus_wr(BASE + 16'd1, 8'h00);
    @(negedge clk); io_addr = BASE + 16'd2; io_wdata = 8'h70; io_wr = 1'b1;
    #1 check("R11 no change before edge", fdc_en, 1'b1);
    @(negedge clk); io_wr = 1'b0;
    check("R11 change after edge", fdc_en, 1'b0);
    wreg(0, 8'h50);
    bus_wr(BASE + 16'd1, 8'h15);
    bus_wr(BASE + 16'd3, 8'h11);
    @(negedge clk); io_addr = BASE + 16'd2; io_wdata = 8'h22;
    @(negedge clk);
    rreg(21, v); check("R11 stray address/no strobe ignored", v, sh[21]);

    // R7/R8/R9: exhaustive sweep
    for (int r1 = 0; r1 < 256; r1++) begin
      wreg(1, 8'(r1));
      for (int o = 0; o < 4; o++) begin
        wreg(3, {4'b0, 2'(o), 2'b0});
        for (int d = 0; d < 16; d++) begin
          wreg(4, {4'(d), 4'b0});
          check("R7 R8 ser0", {ser0_en, ser0_base, ser0_irq}, ser_exp(0, sh[1], sh[3], sh[4]));
          check("R7 R8 ser1", {ser1_en, ser1_base, ser1_irq}, ser_exp(1, sh[1], sh[3], sh[4]));
          check("R9 par", {par_en, par_base, par_irq}, par_exp(sh[1], sh[4]));
        end
      end
    end

    // R4: locked data write ignored, index still accepted
    bus_wr(BASE, 8'h00);
    bus_rd(BASE, v); check("R4 locked key read", v, 8'hFF);
    bus_wr(BASE + 16'd1, 8'h00);
    bus_wr(BASE + 16'd2, 8'h70);
    check("R4 locked write no effect", fdc_en, 1'b1);
    bus_wr(BASE + 16'd1, 8'h15);
    bus_wr(BASE + 16'd2, 8'h77);
    bus_wr(BASE, 8'h89);
    bus_rd(BASE + 16'd1, v); check("R4 index accepted while locked", v, 8'h15);
    bus_rd(BASE + 16'd2, v); check("R4 locked write dropped", v, sh[21]);

    // R6: protection flag
    wreg(9, 8'h40);
    rreg(21, v); check("R6 protected read", v, 8'hFF);
    rreg(7, v); check("R6 register 7 visible", v, sh[7]);
    bus_wr(BASE + 16'd1, 8'h00);
    bus_wr(BASE + 16'd2, 8'h70);
    check("R6 protected write ignored", fdc_en, 1'b1);
    bus_wr(BASE + 16'd1, 8'h09);
    bus_wr(BASE + 16'd2, 8'h00);
    rreg(21, v); check("R6 flag stays set", v, 8'hFF);
    bus_rd(BASE + 16'd1, v); check("R6 index readable", v, 8'h15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule